// File: doc/BRIEF.md
# Stereo Soft-Ramp Digital Attenuator

This block scales a stereo stream of 24-bit signed PCM samples by a per-channel attenuation. Each channel has an 8-bit volume code, where one code step is half a decibel, so the range runs from unity gain down to 127.5 dB of attenuation. Each channel also has its own mute input. Internally the level is kept in eighth-decibel units. The level is turned into a linear multiplier from a small table that covers one halving span, plus an arithmetic right shift for each whole halving.

With soft mode on, a new volume code or a mute does not take effect at once. The applied level moves toward the new target one eighth-decibel unit at a time. A unit is taken only on a sample where the signal crosses zero, so the change makes no click. If the signal stays on one side of zero for too long, a timeout forces the step. With soft mode off, the target is applied on the next sample. A link input makes the second channel follow the first channel's volume code. A freeze input holds newly written settings back and releases them all together.

Top module: `stereo_soft_atten`

## Requirements
- R1: After reset, outValid is 0, both outputs are 0, and both applied levels are 0 (unity), so the first samples pass through unchanged.
- R2: outValid is high exactly one clock after each clock in which inValid is high. The outputs change only in those cycles and hold their value otherwise.
- R3: With an applied level of g eighth-dB units (g < 1023), each output equals sample × 2^(-g/48), rounded and saturated to 24 bits, within ±1 LSB. A level of 0 passes the sample unchanged.
- R4: With softEn low, the target takes effect on the first sample strobe that comes at least one clock after the control change.
- R5: With softEn high and the applied level different from the target, the level moves by exactly one unit toward the target on each strobe whose own sample is a zero crossing. That step already applies to that sample. A zero crossing is a sample equal to zero, or a sample whose sign bit (bit 23) differs from the sign bit of the channel's previous sample. Before the first sample, the previous sign is taken as positive.
- R6: With softEn high and a step pending, the step is taken on the 512th consecutive strobe that has no zero crossing.
- R7: The target of channel A is 4 × volA. The target of channel B is 4 × volB, or 4 × volA while linkEn is high.
- R8: While freezeEn is high, the targets keep the values they had when freeze was raised. On release, all pending changes are taken up at once.
- R9: A muted channel's target is the silence code 1023. An applied level of 1023 gives an output of exactly 0. In soft mode, the level ramps to this code through the R5 mechanism.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample strobe for both channels |
| inLeft | input | 24 | Channel A sample, two's complement |
| inRight | input | 24 | Channel B sample, two's complement |
| volA | input | 8 | Channel A attenuation code, 0.5 dB per step |
| volB | input | 8 | Channel B attenuation code, 0.5 dB per step |
| muteA | input | 1 | Channel A mute |
| muteB | input | 1 | Channel B mute |
| linkEn | input | 1 | Channel B takes channel A's code |
| freezeEn | input | 1 | Hold the targets at their current values |
| softEn | input | 1 | Ramp on zero crossings instead of jumping |
| outValid | output | 1 | Output strobe |
| outLeft | output | 24 | Attenuated channel A sample |
| outRight | output | 24 | Attenuated channel B sample |

## Verification
- **When results are due.** A scaled sample is due on the clock edge that follows its strobe edge. A control change reaches the targets on the first edge after it is driven.
- **How the bench keeps to that timing.**
  - Inputs are driven on falling edges and results are read on the next falling edge.
  - Every strobe pushes one expected pair into a queue. That pair comes from a level model updated with the same zero-crossing, timeout and freeze rules.
  - Each result popped from the queue is compared with ±1 LSB tolerance.
- **Ramp and timeout accuracy.** A ramp step taken one sample early or late, or a timeout off by one, changes the compared value by far more than the tolerance on the large test samples.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int ATT_W = 11;               // level in eighth-dB units
  localparam int STEPS_PER_HALVING = 48;   // 6 dB span in eighth-dB units
  localparam int CODE_SHIFT = 2;           // one volume step = 4 units
  typedef logic [ATT_W-1:0] att_t;
  localparam att_t SILENT_CODE = att_t'(1023);

  typedef struct packed {
    logic load;
    att_t gainL;
    att_t gainR;
  } atten_ctl_t;
endpackage

// File: rtl/atten_ramp_ctl.sv
module atten_ramp_ctl
  import atten_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int VOL_W = 8,
  parameter int ZC_TIMEOUT = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] smpL,
  input  logic [DATA_W-1:0] smpR,
  input  logic [VOL_W-1:0]  volA,
  input  logic [VOL_W-1:0]  volB,
  input  logic              muteA,
  input  logic              muteB,
  input  logic              linkEn,
  input  logic              freezeEn,
  input  logic              softEn,
  output atten_ctl_t        ctl
);
  localparam int CNT_W = $clog2(ZC_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ZC_TIMEOUT - 1);

  logic [VOL_W-1:0] volBSel;
  att_t wantA, wantB, tgtA, tgtB;

  assign volBSel = linkEn ? volA : volB;
  assign wantA = muteA ? SILENT_CODE : (att_t'(volA) << CODE_SHIFT);
  assign wantB = muteB ? SILENT_CODE : (att_t'(volBSel) << CODE_SHIFT);

  // staged targets: frozen while freezeEn is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtA <= '0;
      tgtB <= '0;
    end else if (!freezeEn) begin
      tgtA <= wantA;
      tgtB <= wantB;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : gCh
    att_t tgt, cur, nxt;
    logic [DATA_W-1:0] smp;
    logic prevNeg, zeroCross, pending, fire;
    logic [CNT_W-1:0] quietCnt;

    assign tgt = (ch == 0) ? tgtA : tgtB;
    assign smp = (ch == 0) ? smpL : smpR;
    assign zeroCross = (smp == '0) || (smp[DATA_W-1] != prevNeg);
    assign pending = (cur != tgt);
    assign fire = zeroCross || (quietCnt == CNT_LAST);

    always_comb begin
      nxt = cur;
      if (!softEn) begin
        nxt = tgt;
      end else if (pending && fire) begin
        nxt = (tgt > cur) ? cur + att_t'(1) : cur - att_t'(1);
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cur      <= '0;
        prevNeg  <= 1'b0;
        quietCnt <= '0;
      end else if (inValid) begin
        cur     <= nxt;
        prevNeg <= smp[DATA_W-1];
        if (!softEn || !pending || fire) quietCnt <= '0;
        else quietCnt <= quietCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    ctl.load  = inValid;
    ctl.gainL = gCh[0].nxt;
    ctl.gainR = gCh[1].nxt;
  end
endmodule

// File: rtl/atten_gain_path.sv
module atten_gain_path
  import atten_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  atten_ctl_t        ctl,
  input  logic [DATA_W-1:0] smpL,
  input  logic [DATA_W-1:0] smpR,
  output logic              outValid,
  output logic [DATA_W-1:0] outL,
  output logic [DATA_W-1:0] outR
);
  localparam int FRAC_W = 24;
  localparam int COEF_W = FRAC_W + 1;
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int IDX_W = $clog2(STEPS_PER_HALVING);
  localparam int SH_W = $clog2(PROD_W);
  localparam logic signed [PROD_W-1:0] SAT_HI =
    $signed({{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
  localparam logic signed [PROD_W-1:0] SAT_LO =
    $signed({{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}});

  function automatic logic [COEF_W-1:0] coefAt(int idx);
    real r;
    r = 2.0 ** (-real'(idx) / real'(STEPS_PER_HALVING));
    return COEF_W'($rtoi(r * (2.0 ** FRAC_W) + 0.5));
  endfunction

  logic [COEF_W-1:0] coefTab [STEPS_PER_HALVING];
  for (genvar k = 0; k < STEPS_PER_HALVING; k++) begin : gTab
    localparam logic [COEF_W-1:0] K_COEF = coefAt(k);
    assign coefTab[k] = K_COEF;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : gCh
    att_t gain;
    logic signed [DATA_W-1:0] smp;
    logic [IDX_W-1:0] part;
    logic [SH_W-1:0] totShift;
    logic signed [PROD_W-1:0] prod, bias, rounded;
    logic [DATA_W-1:0] res, held;

    assign gain = (ch == 0) ? ctl.gainL : ctl.gainR;
    assign smp = $signed((ch == 0) ? smpL : smpR);
    assign part = IDX_W'(gain % att_t'(STEPS_PER_HALVING));
    assign totShift = SH_W'(FRAC_W) + SH_W'(gain / att_t'(STEPS_PER_HALVING));
    assign prod = smp * $signed({1'b0, coefTab[part]});
    assign bias = $signed(PROD_W'(1) << (totShift - SH_W'(1)));
    assign rounded = (prod + bias) >>> totShift;

    always_comb begin
      if (gain == SILENT_CODE) res = '0;
      else if (rounded > SAT_HI) res = SAT_HI[DATA_W-1:0];
      else if (rounded < SAT_LO) res = SAT_LO[DATA_W-1:0];
      else res = rounded[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) held <= '0;
      else if (ctl.load) held <= res;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else outValid <= ctl.load;
  end

  assign outL = gCh[0].held;
  assign outR = gCh[1].held;
endmodule

// File: rtl/stereo_soft_atten.sv
module stereo_soft_atten
  import atten_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int VOL_W = 8,
  parameter int ZC_TIMEOUT = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  input  logic [VOL_W-1:0]  volA,
  input  logic [VOL_W-1:0]  volB,
  input  logic              muteA,
  input  logic              muteB,
  input  logic              linkEn,
  input  logic              freezeEn,
  input  logic              softEn,
  output logic              outValid,
  output logic [DATA_W-1:0] outLeft,
  output logic [DATA_W-1:0] outRight
);
  atten_ctl_t ctlBus;

  atten_ramp_ctl #(.DATA_W(DATA_W), .VOL_W(VOL_W), .ZC_TIMEOUT(ZC_TIMEOUT)) ctl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .smpL(inLeft), .smpR(inRight),
    .volA(volA), .volB(volB), .muteA(muteA), .muteB(muteB), .linkEn(linkEn),
    .freezeEn(freezeEn), .softEn(softEn), .ctl(ctlBus)
  );

  atten_gain_path #(.DATA_W(DATA_W)) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .smpL(inLeft), .smpR(inRight),
    .outValid(outValid), .outL(outLeft), .outR(outRight)
  );
endmodule

// File: rtl/atten_checker.sv
module atten_checker
  import atten_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              softEn,
  input logic [DATA_W-1:0] inLeft,
  input logic              outValid,
  input logic [DATA_W-1:0] outLeft,
  input logic [DATA_W-1:0] outRight,
  input atten_ctl_t        ctl
);
  att_t lastL, lastR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastL <= '0;
      lastR <= '0;
    end else if (inValid) begin
      lastL <= ctl.gainL;
      lastR <= ctl.gainR;
    end
  end

  function automatic att_t gap(att_t a, att_t b);
    return (a > b) ? a - b : b - a;
  endfunction

  AST_OUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outLeft) && $stable(outRight))); // R2
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctl.gainL == '0) |=> (outLeft == $past(inLeft))); // R3
  AST_SOFT_STEP_L: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && softEn) |-> (gap(ctl.gainL, lastL) <= att_t'(1))); // R5
  AST_SOFT_STEP_R: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && softEn) |-> (gap(ctl.gainR, lastR) <= att_t'(1))); // R5
  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctl.gainL == SILENT_CODE) |=> (outLeft == '0)); // R9
endmodule

bind stereo_soft_atten atten_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .softEn(softEn), .inLeft(inLeft),
  .outValid(outValid), .outLeft(outLeft), .outRight(outRight), .ctl(ctlBus)
);

// File: tb/stereo_soft_atten_tb_top.sv
module stereo_soft_atten_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SILENT = 1023;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [23:0] inLeft = '0, inRight = '0;
  logic [7:0] volA = '0, volB = '0;
  logic muteA = 0, muteB = 0, linkEn = 0, freezeEn = 0, softEn = 0;
  logic outValid;
  logic [23:0] outLeft, outRight;

  int checks = 0;
  int failures = 0;

  typedef struct { real l; real r; string tag; } exp_t;
  exp_t expQ[$];

  int mG[2], mT[2], mCnt[2];
  bit mPrevNeg[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_soft_atten dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLeft(inLeft), .inRight(inRight),
    .volA(volA), .volB(volB), .muteA(muteA), .muteB(muteB), .linkEn(linkEn),
    .freezeEn(freezeEn), .softEn(softEn), .outValid(outValid),
    .outLeft(outLeft), .outRight(outRight)
  );

  // R7 / R8 / R9: targets follow controls each clock unless frozen
  always @(posedge clk) begin
    if (!rstN) begin
      mT[0] = 0; mT[1] = 0;
    end else if (!freezeEn) begin
      mT[0] = muteA ? SILENT : 4 * int'(volA);
      mT[1] = muteB ? SILENT : 4 * int'(linkEn ? volA : volB);
    end
  end

  task automatic stepModel(int ch, int s);
    bit zc;
    zc = (s == 0) || ((s < 0) != mPrevNeg[ch]);
    if (!softEn) begin
      mG[ch] = mT[ch]; mCnt[ch] = 0;                       // R4
    end else if (mG[ch] != mT[ch]) begin
      if (zc || mCnt[ch] == 511) begin                     // R5, R6
        mG[ch] += (mT[ch] > mG[ch]) ? 1 : -1; mCnt[ch] = 0;
      end else mCnt[ch]++;
    end else mCnt[ch] = 0;
    mPrevNeg[ch] = (s < 0);
  endtask

  function automatic real expVal(int s, int g);
    if (g == SILENT) return 0.0;                           // R9
    return real'(s) * (2.0 ** (-real'(g) / 48.0));         // R3
  endfunction

  task automatic sendSample(int l, int r, string tag);
    exp_t e;
    @(negedge clk);
    inValid = 1'b1; inLeft = 24'(l); inRight = 24'(r);
    stepModel(0, l); stepModel(1, r);
    e.l = expVal(l, mG[0]); e.r = expVal(r, mG[1]); e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected output strobe: actual=1 expected=0");
      end else begin
        exp_t e;
        int aL, aR;
        e = expQ.pop_front();
        aL = $signed(outLeft); aR = $signed(outRight);
        if ((real'(aL) - e.l) > 1.0 || (real'(aL) - e.l) < -1.0 ||
            (real'(aR) - e.r) > 1.0 || (real'(aR) - e.r) < -1.0) begin
          failures++;
          $display("FAIL %s output: actual=(%0d,%0d) expected=(%0.2f,%0.2f)",
                   e.tag, aL, aR, e.l, e.r);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mG = '{0, 0}; mCnt = '{0, 0}; mPrevNeg = '{0, 0}; mT = '{0, 0};
    idle(4);
    // R1: reset state
    checks++;
    if (outValid !== 1'b0 || outLeft !== '0 || outRight !== '0) begin
      failures++;
      $display("FAIL R1 reset outputs: actual=%b/%0h/%0h expected=0/0/0",
               outValid, outLeft, outRight);
    end
    rstN = 1'b1;
    idle(2);
    sendSample(1000, -1000, "R1");
    sendSample(8388607, -8388608, "R3");

    // R4 / R3: immediate mode, different codes
    volA = 8'd12; volB = 8'd40; idle(2);
    sendSample(4000000, -3000000, "R4");
    sendSample(-8388608, 8388607, "R3");
    sendSample(12345, -1, "R3");
    sendSample(0, 7, "R3");

    // R7: link
    linkEn = 1'b1; idle(2);
    sendSample(5000000, 5000000, "R7");
    linkEn = 1'b0; idle(2);
    sendSample(5000000, 5000000, "R7");

    // R8: freeze holds, release applies both together
    freezeEn = 1'b1; volA = 8'd100; volB = 8'd3; idle(2);
    sendSample(6000000, 6000000, "R8");
    sendSample(-6000000, -6000000, "R8");
    freezeEn = 1'b0; idle(2);
    sendSample(6000000, 6000000, "R8");
    sendSample(-6000000, -6000000, "R8");

    // R5: soft ramp, one unit per zero crossing
    softEn = 1'b1; volA = 8'd98; volB = 8'd5; idle(2);
    for (int i = 0; i < 14; i++) begin
      if (i == 7) sendSample(0, 0, "R5");
      else sendSample((i % 2) ? -7000000 : 7000000, (i % 2) ? 7000000 : -7000000, "R5");
    end

    // R6: no crossings, forced step on the 512th strobe
    sendSample(7000000, 7000000, "R6");
    volA = 8'd90; idle(2);
    for (int i = 0; i < 520; i++) sendSample(7000000, 7000000, "R6");

    // R9: soft mute ramp to silence on channel A
    muteA = 1'b1; idle(2);
    for (int i = 0; i < 1100; i++)
      sendSample((i % 2) ? 8000000 : -8000000, (i % 2) ? 3000000 : -3000000, "R9");

    // R9: immediate mute of channel B
    softEn = 1'b0; muteB = 1'b1; idle(2);
    sendSample(8000000, 8000000, "R9");
    sendSample(-8000000, -8000000, "R9");

    idle(4);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R2 missing outputs: actual=%0d pending expected=0", expQ.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule